// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This unit gathers single-cycle event pulses from a command engine and a data-transfer path into sticky status flags that software clears by writing ones. A per-source enable register, topped by one global enable bit, decides which of those flags may raise the interrupt line. A second, independent bank of sticky flags records completion events from an automatic command path. Both banks drive one shared level interrupt output.

Software reads the status word and writes the same value back to acknowledge exactly the events it has seen. Events that arrive while an acknowledge is in progress are never lost. All registers sit on a plain register bus with a write strobe and a combinational read port.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A pulse on `evt_cmd_done`, `evt_xfer_err` or `evt_xfer_req` sets status bit 23, 22 or 21 respectively at offset 0x0 on the next clock edge, whatever the enable bits hold.
- R3: An error pulse and a transfer-request pulse in the same cycle both latch, and a set status bit stays set until software clears it.
- R4: A write to offset 0x0 clears each status bit whose `reg_wdata` bit is 1 and leaves every bit written as 0 unchanged.
- R5: An event pulse in the same cycle as a clearing write to its own bit leaves that bit set (this holds for both status banks).
- R6: The enable register at offset 0x4 stores the global enable at bit 31 and the per-source enables at bits 23, 22 and 21; every other bit reads 0.
- R7: `irq` is high whenever the global enable is set and some main status bit is set together with its enable, or whenever any completion status bit is set; otherwise low.
- R8: A pulse on bit i of `evt_trd_done` sets bit i of the completion status at offset 0x8; a write there clears the bits written as 1.
- R9: Reads from any other offset return 0, and writes there change no register.
- R10: With the global enable clear, main status bits never raise `irq`, but completion status bits still do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cmd_done | input | 1 | Command-done event pulse |
| evt_xfer_err | input | 1 | Data-transfer error event pulse |
| evt_xfer_req | input | 1 | Data-transfer request event pulse |
| evt_trd_done | input | NUM_TRD | Automatic-command completion pulses, one per slot |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions take for granted that events, the write strobe, the address and the write data are synchronous to `clk` and settle well before each rising edge, and that the write strobe carries a valid offset whenever it is high. The bench drives all inputs on the falling edge, holds each write for exactly one cycle, and reads the combinational port only after the rising edge that commits a change. The sweep covers every combination of the three main events, the three source enables and the global enable, plus each completion slot on its own, so the clear-versus-set race is exercised deliberately rather than by chance.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int DATA_W     = 32;
    localparam int MAIN_SRC   = 3;
    localparam int MAIN_LSB   = 21;          // command done 23, error 22, request 21
    localparam int GLB_BIT    = 31;
    localparam int OFF_STAT   = 'h0;
    localparam int OFF_ENABLE = 'h4;
    localparam int OFF_TRD    = 'h8;

    typedef struct packed {
        logic                glb;
        logic [MAIN_SRC-1:0] src;
    } irq_en_t;
endpackage

// File: rtl/irq_w1c_bank.sv
`timescale 1ns/1ps
module irq_w1c_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr_i) begin
            st_d.flags = st_d.flags & ~clr_mask_i;
        end
        // a new event overrides a concurrent acknowledge
        st_d.flags = st_d.flags | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              glb_i,
    input  logic [MAIN_SRC-1:0] src_i,
    output irq_en_t           en_o
);
    irq_en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            en_d.glb = glb_i;
            en_d.src = src_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
module irq_combine
    import irq_pkg::*;
#(
    parameter int NUM_TRD = 8
) (
    input  irq_en_t             en_i,
    input  logic [MAIN_SRC-1:0] main_i,
    input  logic [NUM_TRD-1:0]  trd_i,
    output logic                irq_o
);
    logic main_hit;
    logic trd_hit;

    always_comb begin
        main_hit = en_i.glb && ((main_i & en_i.src) != '0);
        trd_hit  = (trd_i != '0);
        irq_o    = main_hit || trd_hit;
    end
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int NUM_TRD = 8,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_cmd_done,
    input  logic               evt_xfer_err,
    input  logic               evt_xfer_req,
    input  logic [NUM_TRD-1:0] evt_trd_done,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_TRD  = ADDR_W'(OFF_TRD);
    localparam int MAIN_MSB = MAIN_LSB + MAIN_SRC - 1;

    logic [MAIN_SRC-1:0] main_set;
    logic [MAIN_SRC-1:0] main_flags;
    logic [NUM_TRD-1:0]  trd_flags;
    irq_en_t             en_flags;
    logic                wr_stat, wr_en, wr_trd;
    logic                unused_wdata;

    assign main_set = {evt_cmd_done, evt_xfer_err, evt_xfer_req};
    assign wr_stat  = reg_wr && (reg_addr == A_STAT);
    assign wr_en    = reg_wr && (reg_addr == A_EN);
    assign wr_trd   = reg_wr && (reg_addr == A_TRD);
    assign unused_wdata = ^reg_wdata;

    irq_w1c_bank #(.W(MAIN_SRC)) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (main_set),
        .clr_wr_i  (wr_stat),
        .clr_mask_i(reg_wdata[MAIN_MSB:MAIN_LSB]),
        .flags_o   (main_flags)
    );

    irq_w1c_bank #(.W(NUM_TRD)) u_trd (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_trd_done),
        .clr_wr_i  (wr_trd),
        .clr_mask_i(reg_wdata[NUM_TRD-1:0]),
        .flags_o   (trd_flags)
    );

    irq_enable_reg u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_i (wr_en),
        .glb_i(reg_wdata[GLB_BIT]),
        .src_i(reg_wdata[MAIN_MSB:MAIN_LSB]),
        .en_o (en_flags)
    );

    irq_combine #(.NUM_TRD(NUM_TRD)) u_comb (
        .en_i  (en_flags),
        .main_i(main_flags),
        .trd_i (trd_flags),
        .irq_o (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT) begin
            reg_rdata[MAIN_MSB:MAIN_LSB] = main_flags;
        end else if (reg_addr == A_EN) begin
            reg_rdata[GLB_BIT]           = en_flags.glb;
            reg_rdata[MAIN_MSB:MAIN_LSB] = en_flags.src;
        end else if (reg_addr == A_TRD) begin
            reg_rdata[NUM_TRD-1:0] = trd_flags;
        end
    end
endmodule

// File: rtl/irq_status_unit_chk.sv
`timescale 1ns/1ps
module irq_status_unit_chk
    import irq_pkg::*;
#(
    parameter int NUM_TRD = 8,
    parameter int ADDR_W  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                evt_cmd_done,
    input logic                evt_xfer_err,
    input logic                evt_xfer_req,
    input logic [NUM_TRD-1:0]  evt_trd_done,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                irq,
    input logic [MAIN_SRC-1:0] main_q,
    input logic [NUM_TRD-1:0]  trd_q,
    input irq_en_t             en_q
);
    logic stat_wr;
    assign stat_wr = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));

    a_r2_cmd_latch: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmd_done |=> main_q[2]);

    a_r3_both_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_xfer_err && evt_xfer_req) |=> (main_q[1] && main_q[0]));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((main_q & $past(main_q)) == $past(main_q)));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[MAIN_LSB+2] && !evt_cmd_done) |=> !main_q[2]);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[MAIN_LSB+1] && evt_xfer_err) |=> main_q[1]);

    a_r8_trd_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_trd_done != '0) |=> ((trd_q & $past(evt_trd_done)) == $past(evt_trd_done)));

    a_r7_trd_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (trd_q != '0) |-> irq);

    a_r7_main_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q.glb && ((main_q & en_q.src) != '0)) |-> irq);

    a_r10_glb_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q.glb && trd_q == '0) |-> !irq);
endmodule

bind irq_status_unit irq_status_unit_chk #(.NUM_TRD(NUM_TRD), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_cmd_done(evt_cmd_done),
    .evt_xfer_err(evt_xfer_err),
    .evt_xfer_req(evt_xfer_req),
    .evt_trd_done(evt_trd_done),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .main_q      (main_flags),
    .trd_q       (trd_flags),
    .en_q        (en_flags)
);

// File: tb/irq_status_unit_tb.sv
`timescale 1ns/1ps
module irq_status_unit_tb;
    localparam int NT = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_cmd_done = 1'b0, evt_xfer_err = 1'b0, evt_xfer_req = 1'b0;
    logic [NT-1:0] evt_trd_done = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit #(.NUM_TRD(NT), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_cmd_done(evt_cmd_done), .evt_xfer_err(evt_xfer_err), .evt_xfer_req(evt_xfer_req),
        .evt_trd_done(evt_trd_done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_main(input logic [2:0] ev);
        @(negedge clk);
        {evt_cmd_done, evt_xfer_err, evt_xfer_req} = ev;
        @(negedge clk);
        {evt_cmd_done, evt_xfer_err, evt_xfer_req} = 3'b000;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset values
        read(4'h0, rd); check("R1 stat", rd, 32'h0);
        read(4'h4, rd); check("R1 enable", rd, 32'h0);
        read(4'h8, rd); check("R1 trd", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R7 R10: sweep every event set against every enable set
        for (int g = 0; g < 2; g++) begin
            for (int en = 0; en < 8; en++) begin
                for (int ev = 0; ev < 8; ev++) begin
                    logic [31:0] enw;
                    logic        exp_irq;
                    enw = (32'(g) << 31) | (32'(en) << 21);
                    write(4'h0, 32'hFFFF_FFFF);
                    write(4'h4, enw);
                    read(4'h4, rd); check("R6 enable readback", rd, enw);
                    pulse_main(3'(ev));
                    read(4'h0, rd); check("R2 R3 status latch", rd, 32'(ev) << 21);
                    exp_irq = (g == 1) && ((ev & en) != 0);
                    check("R7 R10 irq", {31'b0, irq}, {31'b0, exp_irq});
                end
            end
        end

        // R6: only defined enable bits are stored
        write(4'h4, 32'hFFFF_FFFF);
        read(4'h4, rd); check("R6 reserved bits", rd, 32'h80E0_0000);

        // R4: partial acknowledge
        pulse_main(3'b111);
        write(4'h0, 32'h0040_0000);
        read(4'h0, rd); check("R4 clear bit22", rd, 32'h00A0_0000);
        write(4'h0, 32'h0000_0000);
        read(4'h0, rd); check("R4 zero write keeps", rd, 32'h00A0_0000);
        write(4'h0, 32'h00A0_0000);
        read(4'h0, rd); check("R4 clear rest", rd, 32'h0);
        check("R4 irq drops", {31'b0, irq}, 32'h0);

        // R5: set beats concurrent clear, main bank
        @(negedge clk);
        evt_xfer_err = 1'b1; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h00E0_0000;
        @(negedge clk);
        evt_xfer_err = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        read(4'h0, rd); check("R5 main set wins", rd, 32'h0040_0000);
        write(4'h0, 32'hFFFF_FFFF);

        // R8 R10: completion bank per slot, global enable clear
        write(4'h4, 32'h0);
        for (int i = 0; i < NT; i++) begin
            @(negedge clk);
            evt_trd_done = NT'(1) << i;
            @(negedge clk);
            evt_trd_done = '0;
            read(4'h8, rd); check("R8 trd latch", rd, 32'(1) << i);
            check("R10 trd irq without glb", {31'b0, irq}, 32'h1);
            write(4'h8, 32'(1) << i);
            read(4'h8, rd); check("R8 trd clear", rd, 32'h0);
            check("R7 irq low", {31'b0, irq}, 32'h0);
        end

        // R5: set beats clear, completion bank
        @(negedge clk);
        evt_trd_done = 8'h05; reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'hFF;
        @(negedge clk);
        evt_trd_done = '0; reg_wr = 1'b0; reg_wdata = '0;
        read(4'h8, rd); check("R5 trd set wins", rd, 32'h05);
        write(4'h8, 32'hFF);

        // R9: unmapped offset
        pulse_main(3'b010);
        write(4'h4, 32'h8000_0000);
        write(4'hC, 32'hFFFF_FFFF);
        read(4'hC, rd); check("R9 unmapped read", rd, 32'h0);
        read(4'h0, rd); check("R9 stat untouched", rd, 32'h0040_0000);
        read(4'h4, rd); check("R9 enable untouched", rd, 32'h8000_0000);
        check("R10 enabled src absent", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule